// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block lets an SMBus host read and write a small file of 8-bit configuration registers. It runs entirely on a fast system clock. The SCL and SDA lines are oversampled through synchronizers. START and STOP conditions and SCL edges are recovered from the synchronized samples. A byte-level state machine then walks through the address, register-pointer and data phases. The block never drives SDA high. It only asserts an open-drain pull-down request, and the pad logic outside turns that request into a low level on the wire.

The 7-bit device address is formed from a fixed upper part and four strap inputs, so up to sixteen copies can share one bus. A write places one data byte in the register selected by the pointer byte. A read sets the pointer first, then uses a repeated START and returns one byte. Writing the value 0x01 to register 0 restores every register to its power-on default. A timer watches how long both lines stay high and raises a bus-idle flag. If that flag rises while a transfer is still open, the transfer is dropped.

Top module: `smb_cfg_slave`

## Requirements
- R1: The device address is {3'b101, addr_sel_i}, sent as the upper seven bits of the address byte with R/W in bit 0. With addr_sel_i = 4'b0000 the write address byte is 0xA0; with 4'b1000 it is 0xB0. Any other address byte gets no ACK, and the slave stays silent until the next START.
- R2: While en_i is low the slave never asserts sda_pull_o, and bus activity changes no register.
- R3: Each byte the slave accepts is acknowledged by asserting sda_pull_o (line low) during the ninth SCL clock of that byte. A NACK is the line left released (high).
- R4: The write sequence is START, address byte with R/W=0, register byte, data byte, STOP, with each byte ACKed. It stores the data byte in the addressed register.
- R5: The read sequence is START, address byte with W, register byte, repeated START, address byte with R, then eight data bits. It returns the register contents MSB first. The host's NACK and STOP then end the transfer.
- R6: After reset, register 0 holds 0x00 and register k (k >= 1) holds (0x10 + 3k) mod 256. A write of 0x01 to register 0 puts every register back to these values.
- R7: A START at any point restarts address reception, and a STOP returns the slave to idle. A data byte cut short by either is not stored.
- R8: The slave changes sda_pull_o only while the synchronized SCL is low, so it never creates a START or STOP.
- R9: bus_idle_o is 1 after reset. It clears whenever either line is low. It sets once both lines have been high for TBUF_CYC cycles when the last condition seen was a STOP, and for THIGH_CYC cycles otherwise.
- R10: If bus_idle_o rises while a transfer is open, the transfer is dropped. Later bits without a new START are neither ACKed nor stored.
- R11: A register index at or above NUM_REGS reads as 0x00. A write to such an index is ACKed and discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enables the bus interface when high |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel_i | input | 4 | Strap bits forming the low part of the device address |
| sda_pull_o | output | 1 | Request to pull SDA low (open drain) |
| bus_idle_o | output | 1 | Bus-idle flag from the high-time timer |
| regs_o | output | NUM_REGS*8 | Register file contents, register k in bits [8k+7:8k] |

## Verification
Some rules are checked on every cycle by assertions: SDA is held stable while SCL is high, the pull-down stays quiet when the block is disabled, and a START returns the machine to address reception. The idle flag may rise only with both lines high and must drop when either line goes low. Writes to out-of-range indices must leave the file unchanged, and a soft reset must restore the defaults. Other behaviour can only be shown by the bench's bus scenarios. These cover address matching against the strap pins, the ACK/NACK pattern of whole transactions, the byte returned by a read, and aborts caused by START, STOP or the idle timeout. They also show which of the two idle limits applies after a STOP compared with a long SCL-high hold.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_HACK,
        ST_WAIT
    } fsm_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_REG,
        PH_DATA
    } phase_e;

    typedef struct packed {
        fsm_e       st;
        phase_e     ph;
        logic [2:0] cnt;
        logic       full;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       rd;
        logic       pull;
        logic       idle_p;
    } fsm_t;

    localparam logic [7:0] SOFT_RST_VAL = 8'h01;
    localparam logic [2:0] DEV_ADDR_HI  = 3'b101;

    function automatic logic [7:0] reg_default(input int unsigned k);
        if (k == 0) return 8'h00;
        return 8'((32'h10 + 3 * k) & 32'hFF);
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] scl;
        logic [DEPTH-1:0] sda;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic  scl_p, sda_p;

    always_comb begin
        pipe_d.scl = {pipe_q.scl[DEPTH-2:0], scl_i};
        pipe_d.sda = {pipe_q.sda[DEPTH-2:0], sda_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= pipe_d;
    end

    assign scl_o      = pipe_q.scl[STAGES-1];
    assign sda_o      = pipe_q.sda[STAGES-1];
    assign scl_p      = pipe_q.scl[STAGES];
    assign sda_p      = pipe_q.sda[STAGES];
    assign scl_rise_o = scl_o & ~scl_p;
    assign scl_fall_o = ~scl_o & scl_p;
    assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
    assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;

endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
    parameter int unsigned TBUF_CYC  = 64,
    parameter int unsigned THIGH_CYC = 256
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    input  logic start_i,
    input  logic stop_i,
    output logic idle_o
);
    localparam int unsigned MAXL = (TBUF_CYC > THIGH_CYC) ? TBUF_CYC : THIGH_CYC;
    localparam int unsigned CW   = $clog2(MAXL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          after_stop;
        logic          idle;
    } tmr_t;

    tmr_t       t_d, t_q;
    logic       both_hi;
    logic [CW:0] limit;

    always_comb begin
        t_d     = t_q;
        both_hi = scl_i & sda_i;
        limit   = t_q.after_stop ? (CW+1)'(TBUF_CYC) : (CW+1)'(THIGH_CYC);
        if (stop_i)       t_d.after_stop = 1'b1;
        else if (start_i) t_d.after_stop = 1'b0;
        if (!both_hi) begin
            t_d.cnt  = '0;
            t_d.idle = 1'b0;
        end else begin
            if (t_q.cnt != CW'(MAXL)) t_d.cnt = t_q.cnt + 1'b1;
            if (({1'b0, t_q.cnt} + 1'b1) >= limit) t_d.idle = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '{cnt: '0, after_stop: 1'b1, idle: 1'b1};
        else         t_q <= t_d;
    end

    assign idle_o = t_q.idle;

    // R9: the flag can only rise after a cycle with both lines high
    a_r9_rise_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(idle_o) |-> $past(scl_i && sda_i));

    // R9: a low line drops the flag on the next cycle
    a_r9_low_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(scl_i && sda_i) |=> !idle_o);

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
    import smb_cfg_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  we_i,
    input  logic [7:0]            waddr_i,
    input  logic [7:0]            wdata_i,
    input  logic [7:0]            raddr_i,
    output logic [7:0]            rdata_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int unsigned IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [7:0]            mem_d [NUM_REGS];
    logic [7:0]            mem_q [NUM_REGS];
    logic [NUM_REGS*8-1:0] dflt_flat;
    logic                  soft_rst;

    always_comb begin
        mem_d    = mem_q;
        soft_rst = we_i && (waddr_i == 8'h00) && (wdata_i == SOFT_RST_VAL);
        if (soft_rst) begin
            for (int k = 0; k < NUM_REGS; k++) mem_d[k] = reg_default(k);
        end else if (we_i && (32'(waddr_i) < NUM_REGS)) begin
            mem_d[waddr_i[IW-1:0]] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int k = 0; k < NUM_REGS; k++) mem_q[k] <= reg_default(k);
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = (32'(raddr_i) < NUM_REGS) ? mem_q[raddr_i[IW-1:0]] : 8'h00;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_o[g*8 +: 8]    = mem_q[g];
        assign dflt_flat[g*8 +: 8] = reg_default(g);
    end

    // R11: writes beyond the implemented range leave the file untouched
    a_r11_oob_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && (32'(waddr_i) >= NUM_REGS)) |=> $stable(regs_o));

    // R6: the soft-reset command restores the default image
    a_r6_soft_reset_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && waddr_i == 8'h00 && wdata_i == SOFT_RST_VAL) |=> (regs_o == dflt_flat));

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 16,
    parameter int unsigned TBUF_CYC  = 64,
    parameter int unsigned THIGH_CYC = 256
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  en_i,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [3:0]            addr_sel_i,
    output logic                  sda_pull_o,
    output logic                  bus_idle_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam fsm_t FSM_RST = '{st: ST_IDLE, ph: PH_ADDR, cnt: 3'd0, full: 1'b0,
                                 sh: 8'h00, ptr: 8'h00, rd: 1'b0, pull: 1'b0,
                                 idle_p: 1'b1};

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, idle;
    logic       we, idle_rise;
    logic [7:0] rdata, sh_shift;
    logic [6:0] dev_addr;
    fsm_t       f_d, f_q;

    smb_line_sync #(.STAGES(2)) i_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    smb_idle_timer #(.TBUF_CYC(TBUF_CYC), .THIGH_CYC(THIGH_CYC)) i_idle (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .scl_i   (scl_s),
        .sda_i   (sda_s),
        .start_i (start_det),
        .stop_i  (stop_det),
        .idle_o  (idle)
    );

    smb_regfile #(.NUM_REGS(NUM_REGS)) i_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we),
        .waddr_i (f_q.ptr),
        .wdata_i (f_q.sh),
        .raddr_i (f_q.ptr),
        .rdata_o (rdata),
        .regs_o  (regs_o)
    );

    assign dev_addr = {DEV_ADDR_HI, addr_sel_i};

    always_comb begin
        f_d       = f_q;
        we        = 1'b0;
        sh_shift  = {f_q.sh[6:0], 1'b0};
        idle_rise = idle & ~f_q.idle_p;
        f_d.idle_p = idle;
        if (!en_i) begin
            f_d        = FSM_RST;
            f_d.ptr    = f_q.ptr;
            f_d.idle_p = idle;
        end else if (start_det) begin
            f_d.st   = ST_RX;
            f_d.ph   = PH_ADDR;
            f_d.cnt  = 3'd0;
            f_d.full = 1'b0;
            f_d.pull = 1'b0;
        end else if (stop_det || (idle_rise && f_q.st != ST_IDLE)) begin
            f_d.st   = ST_IDLE;
            f_d.pull = 1'b0;
        end else begin
            unique case (f_q.st)
                ST_RX: begin
                    if (scl_rise && !f_q.full) begin
                        f_d.sh  = {f_q.sh[6:0], sda_s};
                        f_d.cnt = f_q.cnt + 3'd1;
                        if (f_q.cnt == 3'd7) f_d.full = 1'b1;
                    end else if (scl_fall && f_q.full) begin
                        f_d.full = 1'b0;
                        f_d.cnt  = 3'd0;
                        unique case (f_q.ph)
                            PH_ADDR: begin
                                if (f_q.sh[7:1] == dev_addr) begin
                                    f_d.rd   = f_q.sh[0];
                                    f_d.pull = 1'b1;
                                    f_d.st   = ST_ACK;
                                end else begin
                                    f_d.st = ST_WAIT;
                                end
                            end
                            PH_REG: begin
                                f_d.ptr  = f_q.sh;
                                f_d.pull = 1'b1;
                                f_d.st   = ST_ACK;
                            end
                            PH_DATA: begin
                                we       = 1'b1;
                                f_d.pull = 1'b1;
                                f_d.st   = ST_ACK;
                            end
                            default: f_d.st = ST_WAIT;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        f_d.cnt = 3'd0;
                        if (f_q.ph == PH_ADDR && f_q.rd) begin
                            f_d.sh   = rdata;
                            f_d.pull = ~rdata[7];
                            f_d.st   = ST_TX;
                        end else begin
                            f_d.pull = 1'b0;
                            f_d.st   = (f_q.ph == PH_DATA) ? ST_WAIT : ST_RX;
                            f_d.ph   = (f_q.ph == PH_ADDR) ? PH_REG : PH_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        f_d.cnt = f_q.cnt + 3'd1;
                        f_d.sh  = sh_shift;
                        if (f_q.cnt == 3'd7) begin
                            f_d.pull = 1'b0;
                            f_d.st   = ST_HACK;
                        end else begin
                            f_d.pull = ~sh_shift[7];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_fall) f_d.st = ST_WAIT;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= FSM_RST;
        else         f_q <= f_d;
    end

    assign sda_pull_o = f_q.pull;
    assign bus_idle_o = idle;

    // R2: disabled interface releases the line
    a_r2_off_is_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !sda_pull_o);

    // R8: no change to the pull-down while synchronized SCL was high
    a_r8_drive_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(en_i) && en_i && $past(scl_s)) |-> $stable(sda_pull_o));

    // R7: a START puts the machine back into address reception
    a_r7_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && start_det) |=> (f_q.st == ST_RX && f_q.ph == PH_ADDR && f_q.cnt == 3'd0));

endmodule

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;
    localparam int NR = 16;
    localparam int TB = 64;
    localparam int TH = 256;
    localparam int Q  = 4;

    typedef struct {
        string      tag;
        logic [7:0] v;
    } item_t;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            en    = 1'b1;
    logic            scl_h = 1'b1;
    logic            sda_h = 1'b1;
    logic [3:0]      sel   = 4'b0000;
    wire             sda_pull;
    wire             bus_idle;
    wire [NR*8-1:0]  regs;
    wire             sda_line = sda_h & ~sda_pull;

    smb_cfg_slave #(.NUM_REGS(NR), .TBUF_CYC(TB), .THIGH_CYC(TH)) i_smb_cfg_slave (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .scl_i      (scl_h),
        .sda_i      (sda_line),
        .addr_sel_i (sel),
        .sda_pull_o (sda_pull),
        .bus_idle_o (bus_idle),
        .regs_o     (regs)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    bit    pull_seen = 0;
    item_t exp_q[$];
    item_t got_q[$];

    function automatic logic [7:0] dflt(input int k);
        return (k == 0) ? 8'h00 : 8'((16 + 3 * k) & 255);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (sda_pull) pull_seen = 1'b1;
        while (exp_q.size() > 0 && got_q.size() > 0) begin
            item_t e;
            item_t g;
            e = exp_q.pop_front();
            g = got_q.pop_front();
            check(e.tag, {24'h0, g.v}, {24'h0, e.v});
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic hbit(input logic b, output logic s);
        sda_h = b; wq();
        scl_h = 1'b1; wq();
        s = sda_line; wq();
        scl_h = 1'b0; wq();
    endtask

    task automatic hstart();
        sda_h = 1'b1; wq();
        scl_h = 1'b1; wq();
        sda_h = 1'b0; wq();
        scl_h = 1'b0; wq();
    endtask

    task automatic hstop();
        sda_h = 1'b0; wq();
        scl_h = 1'b1; wq();
        sda_h = 1'b1; wq();
    endtask

    task automatic send_ack(input logic [7:0] b, input logic exp_ack, input string tag);
        logic s;
        logic a;
        exp_q.push_back('{tag, {7'h0, exp_ack}});
        for (int i = 7; i >= 0; i--) hbit(b[i], s);
        hbit(1'b1, a);
        got_q.push_back('{tag, {7'h0, a}});
    endtask

    task automatic recv_chk(input logic [7:0] exp_v, input string tag);
        logic [7:0] v;
        logic       s;
        exp_q.push_back('{tag, exp_v});
        for (int i = 7; i >= 0; i--) begin
            hbit(1'b1, s);
            v[i] = s;
        end
        hbit(1'b1, s);
        got_q.push_back('{tag, v});
    endtask

    task automatic do_write(input logic [7:0] dev, rg, dat, input logic [2:0] acks,
                            input string tag);
        hstart();
        send_ack(dev, acks[2], tag);
        send_ack(rg,  acks[1], tag);
        send_ack(dat, acks[0], tag);
        hstop();
        wq();
    endtask

    task automatic do_read(input logic [7:0] dev, rg, input logic [2:0] acks,
                           input logic [7:0] exp_v, input string tag);
        hstart();
        send_ack(dev, acks[2], tag);
        send_ack(rg,  acks[1], tag);
        hstart();
        send_ack(dev | 8'h01, acks[0], tag);
        recv_chk(exp_v, tag);
        hstop();
        wq();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [NR*8-1:0] snap;
        logic            s;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6 reset state, R9 idle after reset
        check("R6 reset pull", {31'h0, sda_pull}, 32'h0);
        check("R9 idle after reset", {31'h0, bus_idle}, 32'h1);
        for (int k = 0; k < NR; k++) check("R6 reset default", {24'h0, regs[k*8 +: 8]}, {24'h0, dflt(k)});

        // R4 write, R3 ack pattern
        do_write(8'hA0, 8'h03, 8'hC5, 3'b000, "R3 R4 write acks");
        check("R4 stored", {24'h0, regs[3*8 +: 8]}, 32'hC5);

        // R5 read back written and default values
        do_read(8'hA0, 8'h03, 3'b000, 8'hC5, "R5 read reg3");
        do_read(8'hA0, 8'h05, 3'b000, dflt(5), "R5 read reg5 default");

        // R1 address mismatch
        do_write(8'hA2, 8'h04, 8'h77, 3'b111, "R1 mismatch nack");
        check("R1 mismatch no write", {24'h0, regs[4*8 +: 8]}, {24'h0, dflt(4)});

        // R1 strap bits 1000 -> 0xB0
        sel = 4'b1000;
        do_write(8'hB0, 8'h07, 8'h3C, 3'b000, "R1 strap B0 write");
        check("R1 strap write stored", {24'h0, regs[7*8 +: 8]}, 32'h3C);
        do_read(8'hB0, 8'h07, 3'b000, 8'h3C, "R1 strap B0 read");
        do_write(8'hA0, 8'h07, 8'h11, 3'b111, "R1 old address nack");
        check("R1 old address no write", {24'h0, regs[7*8 +: 8]}, 32'h3C);
        sel = 4'b0000;

        // R11 unimplemented index
        snap = regs;
        do_write(8'hA0, 8'h40, 8'h99, 3'b000, "R11 oob write acked");
        check("R11 oob write discarded", (regs == snap) ? 32'h1 : 32'h0, 32'h1);
        do_read(8'hA0, 8'h40, 3'b000, 8'h00, "R11 oob read zero");

        // R6 soft reset
        do_write(8'hA0, 8'h00, 8'h01, 3'b000, "R6 soft reset acks");
        for (int k = 0; k < NR; k++) check("R6 soft reset default", {24'h0, regs[k*8 +: 8]}, {24'h0, dflt(k)});

        // R2 disabled
        en = 1'b0;
        pull_seen = 1'b0;
        do_write(8'hA0, 8'h02, 8'h55, 3'b111, "R2 disabled nack");
        check("R2 no pull while disabled", {31'h0, pull_seen}, 32'h0);
        check("R2 no write while disabled", {24'h0, regs[2*8 +: 8]}, {24'h0, dflt(2)});
        en = 1'b1;

        // R7 START inside a data byte aborts it
        hstart();
        send_ack(8'hA0, 1'b0, "R7 abort setup");
        send_ack(8'h02, 1'b0, "R7 abort setup");
        hbit(1'b1, s); hbit(1'b0, s); hbit(1'b1, s); hbit(1'b0, s);
        hstart();
        send_ack(8'hA0, 1'b0, "R7 restart address");
        send_ack(8'h09, 1'b0, "R7 restart reg");
        send_ack(8'h42, 1'b0, "R7 restart data");
        hstop();
        wq();
        check("R7 partial byte dropped", {24'h0, regs[2*8 +: 8]}, {24'h0, dflt(2)});
        check("R7 restarted write stored", {24'h0, regs[9*8 +: 8]}, 32'h42);

        // R7 STOP inside a data byte
        hstart();
        send_ack(8'hA0, 1'b0, "R7 stop setup");
        send_ack(8'h02, 1'b0, "R7 stop setup");
        hbit(1'b0, s); hbit(1'b1, s);
        hstop();
        wq();
        check("R7 stop drops byte", {24'h0, regs[2*8 +: 8]}, {24'h0, dflt(2)});

        // R9 idle after STOP uses the short limit
        do_write(8'hA0, 8'h0A, 8'h5A, 3'b000, "R9 setup write");
        repeat (20) @(negedge clk);
        check("R9 not idle before bus-free time", {31'h0, bus_idle}, 32'h0);
        repeat (60) @(negedge clk);
        check("R9 idle after bus-free time", {31'h0, bus_idle}, 32'h1);

        // R9/R10 long SCL-high hold without STOP
        hstart();
        send_ack(8'hA0, 1'b0, "R10 setup");
        send_ack(8'h06, 1'b0, "R10 setup");
        sda_h = 1'b1; wq();
        scl_h = 1'b1;
        repeat (120) @(negedge clk);
        check("R9 long-high limit not yet", {31'h0, bus_idle}, 32'h0);
        repeat (200) @(negedge clk);
        check("R9 long-high idle", {31'h0, bus_idle}, 32'h1);
        scl_h = 1'b0; wq();
        exp_q.push_back('{"R10 timed-out byte nack", 8'h01});
        for (int i = 6; i >= 0; i--) hbit(1'(8'hAB >> i), s);
        hbit(1'b1, s);
        got_q.push_back('{"R10", {7'h0, s}});
        hstop();
        wq();
        check("R10 timed-out byte not stored", {24'h0, regs[6*8 +: 8]}, {24'h0, dflt(6)});

        repeat (10) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'h0);
        summary();
    end

endmodule